// File: doc/BRIEF.md
# Dual 8-bit Event/Interval Timer with Output Compare

The block holds two independent 8-bit up-counters, a high half and a low half. Both halves advance on one shared count tick. A small register port configures the tick source. The source is either edges on an external event pin, with the polarity selectable, or one of four taps of a free-running internal prescaler. Each half compares its count against its own compare register. It raises a compare-match flag when the count arrives at that value and an overflow flag when it wraps from 0xFF to 0x00. A half can optionally return to zero on the tick after a match, which turns it into a programmable-period interval timer.

Flags can only be set by the counting logic. Software clears a flag with a two-step handshake: it reads the status register while the flag is 1, then writes 0 to that bit. Each half drives an interrupt line that is the AND of its overflow flag and its overflow interrupt enable.

Register map, selected by `addr_i`: 0 = control, 1 = status, 2 = high count, 3 = low count, 4 = high compare, 5 = low compare. Reads are combinational from `addr_i`. A read access counts for the clear handshake only when `re_i` is high at a clock edge.

Top module: `dual_timer8`

## Requirements
- R1: After reset, the control, status, count and compare registers all read 0x00, and both interrupt outputs are low.
- R2: Control bits [2:0] select an internal tick. Code 100 gives one tick every 32 clocks, 101 every 16, 110 every 4 and 111 every 2.
- R3: When control bit 2 is 0, the counters advance once per edge of the synchronised external event input, whatever bits [1:0] hold. Control bit 3 = 1 selects rising edges and 0 selects falling edges.
- R4: Each half increments on every tick. When a tick takes a half from 0xFF to 0x00, that half's overflow flag is set.
- R5: A half's compare flag is set by a tick that brings its count equal to its compare register.
- R6: With clear-on-compare enabled, a half whose count equals its compare value goes to 0x00 on the next tick. With it disabled, the half keeps counting upward.
- R7: The status register holds, from bit 7 to bit 0: high overflow, high compare, high overflow-interrupt enable, high clear-on-compare, low overflow, low compare, low overflow-interrupt enable, low clear-on-compare.
- R8: Writing 1 to a flag bit never sets it. The enable and clear-on-compare bits are plain read/write.
- R9: A flag clears only when 0 is written to it after a status read (with `re_i`) returned it as 1. A 0 written without such a read leaves the flag set, and any status write ends the read-armed state.
- R10: If the hardware sets a flag again after the arming read, a later 0 write leaves it set. A hardware set wins over a clear in the same cycle.
- R11: `irq_hi_o` and `irq_lo_o` each equal their half's overflow flag ANDed with its overflow interrupt enable.
- R12: The count and compare registers can be written and read back. A count write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_evt_i | input | 1 | External event input (asynchronous) |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (arms flag clears) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_hi_o | output | 1 | High half overflow interrupt |
| irq_lo_o | output | 1 | Low half overflow interrupt |

## Verification
The bench builds the block with its default parameters: a 5-bit prescaler and a 2-stage input synchroniser. With these values, all four internal rates show up as exact tick counts over a 64-clock window. An external pulse takes effect three clocks after the pin moves, so every event-driven scenario can be stepped one tick at a time. This lets the bench place the counters just below a wrap or a match and observe flags, clears and re-arming deterministically.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_CNT_H = 3'd2,
    A_CNT_L = 3'd3,
    A_OCR_H = 3'd4,
    A_OCR_L = 3'd5
  } reg_addr_e;

  // one nibble of the status register per half
  typedef struct packed {
    logic ovf;
    logic cmf;
    logic ovie;
    logic cclr;
  } half_stat_t;
endpackage

// File: rtl/dt_tick_gen.sv
module dt_tick_gen #(
  parameter int PRE_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic [2:0] sel_i,
  input  logic       edge_rise_i,
  output logic       tick_o
);
  localparam int TAP_SLOW = PRE_W;
  localparam int TAP_MED  = PRE_W - 1;
  localparam int TAP_FAST = 2;
  localparam int TAP_MAX  = 1;

  logic [PRE_W-1:0]  pre_q;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_lvl, ext_edge;

  function automatic logic tap_hit(input logic [PRE_W-1:0] p, input int n);
    logic [PRE_W-1:0] m;
    m = PRE_W'((1 << n) - 1);
    return (p & m) == m;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[SYNC_N-2:0], ext_i};
      prev_q <= ext_lvl;
    end
  end

  assign ext_lvl  = sync_q[SYNC_N-1];
  assign ext_edge = edge_rise_i ? (ext_lvl & ~prev_q) : (~ext_lvl & prev_q);

  always_comb begin
    unique case (sel_i)
      3'b100:  tick_o = tap_hit(pre_q, TAP_SLOW);
      3'b101:  tick_o = tap_hit(pre_q, TAP_MED);
      3'b110:  tick_o = tap_hit(pre_q, TAP_FAST);
      3'b111:  tick_o = tap_hit(pre_q, TAP_MAX);
      default: tick_o = ext_edge;
    endcase
  end

  // R2/R3: with a steady source, ticks are single-cycle pulses
  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!$stable(sel_i) || !$stable(edge_rise_i) || !tick_o));
endmodule

// File: rtl/dt_half.sv
module dt_half
  import dt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ocr_i,
  input  logic             wr_stat_i,
  input  logic             rd_stat_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  half_stat_t       wstat_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ocr_o,
  output half_stat_t       stat_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, ocr_q, cnt_inc, cnt_tick;
  logic ovf_q, cmf_q, ovie_q, cclr_q;
  logic arm_ovf_q, arm_cmf_q;
  logic match, wrap, adv, ovf_set, cmf_set;

  assign match    = (cnt_q == ocr_q);
  assign wrap     = (cnt_q == {CNT_W{1'b1}});
  assign adv      = tick_i & ~wr_cnt_i;
  assign cnt_inc  = cnt_q + 1'b1;
  assign cnt_tick = (cclr_q && match) ? '0 : cnt_inc;
  assign ovf_set  = adv & wrap;
  assign cmf_set  = adv & (cnt_tick == ocr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ocr_q <= '0;
    end else begin
      if (wr_cnt_i)    cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= cnt_tick;
      if (wr_ocr_i)    ocr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovie_q <= 1'b0;
      cclr_q <= 1'b0;
    end else if (wr_stat_i) begin
      ovie_q <= wstat_i.ovie;
      cclr_q <= wstat_i.cclr;
    end
  end

  // hardware set > armed clear > arming read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q     <= 1'b0;
      arm_ovf_q <= 1'b0;
    end else if (ovf_set) begin
      ovf_q     <= 1'b1;
      arm_ovf_q <= 1'b0;
    end else if (wr_stat_i) begin
      if (arm_ovf_q && !wstat_i.ovf) ovf_q <= 1'b0;
      arm_ovf_q <= 1'b0;
    end else if (rd_stat_i && ovf_q) begin
      arm_ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmf_q     <= 1'b0;
      arm_cmf_q <= 1'b0;
    end else if (cmf_set) begin
      cmf_q     <= 1'b1;
      arm_cmf_q <= 1'b0;
    end else if (wr_stat_i) begin
      if (arm_cmf_q && !wstat_i.cmf) cmf_q <= 1'b0;
      arm_cmf_q <= 1'b0;
    end else if (rd_stat_i && cmf_q) begin
      arm_cmf_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign ocr_o  = ocr_q;
  assign stat_o = '{ovf: ovf_q, cmf: cmf_q, ovie: ovie_q, cclr: cclr_q};
  assign irq_o  = ovf_q & ovie_q;

  assert_wrap_sets_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0 && ovf_q));

  assert_cmp_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i && !(cclr_q && cnt_q == ocr_q) && !wr_ocr_i
     && CNT_W'(cnt_q + 1'b1) == ocr_q) |=> cmf_q);

  assert_clear_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i && cclr_q && cnt_q == ocr_q) |=> (cnt_q == '0));

  assert_ovf_hw_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_q && !(tick_i && cnt_q == {CNT_W{1'b1}})) |=> !ovf_q);

  assert_cmf_hw_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmf_q && !tick_i) |=> !cmf_q);

  assert_ovf_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !arm_ovf_q) |=> ovf_q);

  assert_cmf_needs_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmf_q && !arm_cmf_q) |=> cmf_q);

  assert_count_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
  import dt_pkg::*;
#(
  parameter int PRE_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_evt_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_hi_o,
  output logic             irq_lo_o
);
  localparam int N_HALF = 2;
  localparam int HI     = 1;
  localparam int LO     = 0;

  logic [2:0]       sel_q;
  logic             edge_rise_q;
  logic             tick;
  logic             wr_stat, rd_stat;
  logic [CNT_W-1:0] cnt   [N_HALF];
  logic [CNT_W-1:0] ocr   [N_HALF];
  half_stat_t       stat  [N_HALF];
  logic [N_HALF-1:0] irq;

  assign wr_stat = we_i && (addr_i == A_STAT);
  assign rd_stat = re_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      edge_rise_q <= 1'b0;
    end else if (we_i && addr_i == A_CTRL) begin
      sel_q       <= wdata_i[2:0];
      edge_rise_q <= wdata_i[3];
    end
  end

  dt_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_i       (ext_evt_i),
    .sel_i       (sel_q),
    .edge_rise_i (edge_rise_q),
    .tick_o      (tick)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam logic [2:0] CNT_A = (h == HI) ? A_CNT_H : A_CNT_L;
    localparam logic [2:0] OCR_A = (h == HI) ? A_OCR_H : A_OCR_L;

    dt_half u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .wr_cnt_i  (we_i && addr_i == CNT_A),
      .wr_ocr_i  (we_i && addr_i == OCR_A),
      .wr_stat_i (wr_stat),
      .rd_stat_i (rd_stat),
      .wdata_i   (wdata_i),
      .wstat_i   (half_stat_t'(wdata_i[4*h +: 4])),
      .cnt_o     (cnt[h]),
      .ocr_o     (ocr[h]),
      .stat_o    (stat[h]),
      .irq_o     (irq[h])
    );
  end

  assign irq_hi_o = irq[HI];
  assign irq_lo_o = irq[LO];

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {4'b0, edge_rise_q, sel_q};
      A_STAT:  rdata_o = {stat[HI], stat[LO]};
      A_CNT_H: rdata_o = cnt[HI];
      A_CNT_L: rdata_o = cnt[LO];
      A_OCR_H: rdata_o = ocr[HI];
      A_OCR_L: rdata_o = ocr[LO];
      default: rdata_o = '0;
    endcase
  end

  assert_irq_follows_stat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o == (stat[LO].ovf && stat[LO].ovie)) && (irq_hi_o == (stat[HI].ovf && stat[HI].ovie)));
endmodule

// File: tb/tb_dual_timer8.sv
module tb_dual_timer8;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNTH = 3'd2, CNTL = 3'd3,
                         OCRH = 3'd4, OCRL = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_hi, irq_lo;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer8 dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_evt_i(ext), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // look at a register without arming flag clears
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // read access that arms flag clears
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk); ext = 1'b1;
    repeat (4) @(negedge clk);
    ext = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(CTRL, v); chk("R1 ctrl", v, 8'h00);
    peek(STAT, v); chk("R1 stat", v, 8'h00);
    peek(CNTL, v); chk("R1 cnt_lo", v, 8'h00);
    peek(CNTH, v); chk("R1 cnt_hi", v, 8'h00);
    peek(OCRL, v); chk("R1 ocr_lo", v, 8'h00);
    chk("R1 irq", {irq_hi, irq_lo}, 0);
  endtask

  task automatic t_ext_rise;
    logic [7:0] v;
    wr(CTRL, 8'h0B);
    wr(CNTL, 8'h00); wr(CNTH, 8'h10);
    wr(OCRL, 8'h80); wr(OCRH, 8'h80);
    peek(OCRL, v); chk("R12 ocr readback", v, 8'h80);
    peek(CNTH, v); chk("R12 cnt readback", v, 8'h10);
    repeat (5) pulse();
    peek(CNTL, v); chk("R3 rising count lo", v, 8'h05);
    peek(CNTH, v); chk("R3 rising count hi", v, 8'h15);
  endtask

  task automatic t_ext_fall;
    logic [7:0] v;
    wr(CTRL, 8'h01);
    @(negedge clk); ext = 1'b1;
    repeat (8) @(negedge clk);
    peek(CNTL, v); chk("R3 no tick on rise in falling mode", v, 8'h05);
    ext = 1'b0;
    repeat (8) @(negedge clk);
    peek(CNTL, v); chk("R3 falling edge tick", v, 8'h06);
  endtask

  task automatic t_rates;
    logic [7:0] a, b;
    int exp [4] = '{2, 4, 16, 32};
    for (int i = 0; i < 4; i++) begin
      wr(CTRL, 8'(4 + i));
      peek(CNTL, a);
      repeat (64) @(negedge clk);
      #1 b = rdata;
      chk($sformatf("R2 rate code %0d", 4 + i), 8'(b - a), exp[i]);
    end
    wr(CTRL, 8'h08);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    wr(CNTL, 8'hFE); wr(CNTH, 8'h40);
    pulse();
    peek(CNTL, v); chk("R4 at 0xFF", v, 8'hFF);
    peek(STAT, v); chk("R4 no flag before wrap", v, 8'h00);
    pulse();
    peek(CNTL, v); chk("R4 wrapped", v, 8'h00);
    peek(STAT, v); chk("R4 R7 low ovf bit3", v, 8'h08);
    peek(CNTH, v); chk("R4 hi counts on", v, 8'h42);
    chk("R11 irq low while disabled", irq_lo, 0);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(STAT, 8'hCE);
    peek(STAT, v); chk("R8 ones do not set flags", v, 8'h0A);
    chk("R11 irq_lo", irq_lo, 1);
    chk("R11 irq_hi", irq_hi, 0);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(STAT, 8'h02);
    peek(STAT, v); chk("R9 zero without read keeps flag", v, 8'h0A);
    rd(STAT, v); chk("R9 arming read", v, 8'h0A);
    wr(STAT, 8'h02);
    peek(STAT, v); chk("R9 cleared after read", v, 8'h02);
    chk("R11 irq drops", irq_lo, 0);
  endtask

  task automatic t_compare;
    logic [7:0] v;
    wr(STAT, 8'h01);
    wr(OCRL, 8'h03); wr(CNTL, 8'h02);
    wr(OCRH, 8'h03); wr(CNTH, 8'h02);
    pulse();
    peek(CNTL, v); chk("R5 lo reaches compare", v, 8'h03);
    peek(STAT, v); chk("R5 R7 both cmf", v, 8'h45);
    pulse();
    peek(CNTL, v); chk("R6 clear on match", v, 8'h00);
    peek(CNTH, v); chk("R6 no clear keeps counting", v, 8'h04);
  endtask

  task automatic t_rearm;
    logic [7:0] v;
    rd(STAT, v); chk("R10 arming read", v, 8'h45);
    wr(CNTL, 8'h02);
    pulse();
    wr(STAT, 8'h01);
    peek(STAT, v); chk("R10 re-set flag survives, armed one clears", v, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ext_rise();
    t_ext_fall();
    t_rates();
    t_overflow();
    t_irq();
    t_clear();
    t_compare();
    t_rearm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule